// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Counter

This block sits after an external two-ratio prescaler and counts the prescaler's output edges. Its clock is that prescaler output. It drives one modulus-select line back to the prescaler. The line is low, which selects the higher ratio P+1, for the first A edges of a count cycle. It is high, which selects the lower ratio P, for the rest of the cycle. The count cycle is M edges long. Over one cycle the block therefore spans A·(P+1) + (M−A)·P = M·P + A input periods of the prescaler.

A one-clock terminal pulse marks the last edge of each cycle and is meant for a phase detector. New M and A values are taken in on a load strobe. The same strobe clears both counters, so the very next clock period is the first period of a fresh cycle that uses the new values. A load with M ≤ A raises an error flag. The counters still run the same sequence in that case.

Top module: `pswallow_counter`

## Requirements
- R1: Within a count cycle, call the clock periods k = 0 … M−1. `modCtrl` is 0 in every period k < A.
- R2: `modCtrl` is 1 in every period with A ≤ k ≤ M−1. It never falls inside a cycle.
- R3: `termPulse` is 1 only in period k = M−1. The pulse is one clock wide, so exactly one pulse arrives every M clocks. With `modCtrl` low selecting P+1, this spans M·P + A prescaler input periods.
- R4: With A = 0, `modCtrl` is 1 for the whole cycle, which gives a division of M·P.
- R5: A clock edge with `loadEn` = 1 stores `mValue` and `aValue` and clears both counters, even in the middle of a cycle. The next period is k = 0 of a new cycle that uses the new values. `termPulse` is 0 in that period.
- R6: Each load sets `cfgError` to 1 if `mValue` ≤ `aValue` and to 0 otherwise. The flag holds until the next load. With M ≤ A, `modCtrl` stays 0 for the whole cycle and the cycle is still M clocks long.
- R7: The extreme legal values work as stated in R1 to R3: M = 1023 with A = 127.
- R8: After reset the block is in period k = 0 with the default values M = `DEF_M` (8) and A = `DEF_A` (0). In that state `modCtrl` = 1, `termPulse` = 0 and `cfgError` = 0, and the first pulse comes in the 8th period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output; counted on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Load strobe: store new values and restart the cycle |
| mValue | input | M_W (10) | New M count, legal 8 to 1023 |
| aValue | input | A_W (7) | New A count, legal 0 to 127 |
| modCtrl | output | 1 | Modulus select: 0 selects P+1, 1 selects P |
| termPulse | output | 1 | One-clock pulse in the last period of the cycle |
| cfgError | output | 1 | The last load had M ≤ A |

## Verification
The bench builds the block with its default widths, M_W = 10 and A_W = 7, and the default reset values M = 8, A = 0. Full-width counters put the longest cycle, M = 1023 with A = 127, within reach, along with the saturation point of the A counter. The small default M keeps the reset-state cycle short enough to check edge by edge. The same build also reaches the A = 0 case, loads with M ≤ A, and a reload in the middle of a cycle.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  // Strobes from control to datapath; at most one is active per cycle.
  typedef struct packed {
    logic loadRegs;   // take new values, clear counters
    logic wrapCycle;  // last period reached: clear counters
    logic stepCount;  // advance position within the cycle
  } cntStrobe_t;

  // Status from datapath to control, describing the current period.
  typedef struct packed {
    logic lastPeriod; // current period is M-1
    logic nextIsLast; // next period will be M-1
    logic nextPastA;  // next period index is >= A
    logic aRegZero;   // stored A is zero
  } cntStatus_t;

endpackage

// File: rtl/pswallow_datapath.sv
module pswallow_datapath
  import pswallow_pkg::*;
#(
  parameter int M_W   = 10,
  parameter int A_W   = 7,
  parameter int DEF_M = 8,
  parameter int DEF_A = 0
) (
  input  logic           clk,
  input  logic           rstN,
  input  cntStrobe_t     strobe,
  input  logic [M_W-1:0] mValue,
  input  logic [A_W-1:0] aValue,
  output cntStatus_t     status
);

  localparam int CW = ((M_W > A_W) ? M_W : A_W) + 2;

  logic [M_W-1:0] mReg;
  logic [M_W-1:0] mCnt;
  logic [A_W-1:0] aReg;
  logic [A_W-1:0] aCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mReg <= M_W'(DEF_M);
      aReg <= A_W'(DEF_A);
      mCnt <= '0;
      aCnt <= '0;
    end else if (strobe.loadRegs) begin
      mReg <= mValue;
      aReg <= aValue;
      mCnt <= '0;
      aCnt <= '0;
    end else if (strobe.wrapCycle) begin
      mCnt <= '0;
      aCnt <= '0;
    end else if (strobe.stepCount) begin
      mCnt <= mCnt + 1'b1;
      // The swallow counter stops once it has reached A.
      if (aCnt != aReg) aCnt <= aCnt + 1'b1;
    end
  end

  logic [CW-1:0] mRegX, mCntX, aRegX, aCntX;

  always_comb begin
    mRegX = CW'(mReg);
    mCntX = CW'(mCnt);
    aRegX = CW'(aReg);
    aCntX = CW'(aCnt);
    status.lastPeriod = (mCntX + CW'(1) == mRegX);
    status.nextIsLast = (mCntX + CW'(2) == mRegX);
    status.nextPastA  = (aCntX + CW'(1) >= aRegX);
    status.aRegZero   = (aReg == '0);
  end

endmodule

// File: rtl/pswallow_control.sv
module pswallow_control
  import pswallow_pkg::*;
#(
  parameter bit DEF_A_ZERO = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEn,
  input  logic       loadAZero,
  input  logic       loadBad,
  input  cntStatus_t status,
  output cntStrobe_t strobe,
  output logic       modCtrl,
  output logic       termPulse,
  output logic       cfgError
);

  always_comb begin
    strobe.loadRegs  = loadEn;
    strobe.wrapCycle = !loadEn && status.lastPeriod;
    strobe.stepCount = !loadEn && !status.lastPeriod;
  end

  // Outputs are registered and hold the values of the period that begins at this edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modCtrl   <= DEF_A_ZERO;
      termPulse <= 1'b0;
      cfgError  <= 1'b0;
    end else if (strobe.loadRegs) begin
      modCtrl   <= loadAZero;
      termPulse <= 1'b0;
      cfgError  <= loadBad;
    end else if (strobe.wrapCycle) begin
      modCtrl   <= status.aRegZero;
      termPulse <= 1'b0;
    end else begin
      modCtrl   <= status.nextPastA;
      termPulse <= status.nextIsLast;
    end
  end

endmodule

// File: rtl/pswallow_counter.sv
module pswallow_counter
  import pswallow_pkg::*;
#(
  parameter int M_W   = 10,
  parameter int A_W   = 7,
  parameter int DEF_M = 8,
  parameter int DEF_A = 0
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           loadEn,
  input  logic [M_W-1:0] mValue,
  input  logic [A_W-1:0] aValue,
  output logic           modCtrl,
  output logic           termPulse,
  output logic           cfgError
);

  localparam int CW = ((M_W > A_W) ? M_W : A_W) + 1;
  localparam bit DEF_A_ZERO = (DEF_A == 0);

  cntStrobe_t strobe;
  cntStatus_t status;
  logic       loadAZero;
  logic       loadBad;

  always_comb begin
    loadAZero = (aValue == '0);
    loadBad   = (CW'(mValue) <= CW'(aValue));
  end

  pswallow_datapath #(
    .M_W(M_W), .A_W(A_W), .DEF_M(DEF_M), .DEF_A(DEF_A)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .mValue(mValue), .aValue(aValue), .status(status)
  );

  pswallow_control #(
    .DEF_A_ZERO(DEF_A_ZERO)
  ) i_control (
    .clk(clk), .rstN(rstN), .loadEn(loadEn),
    .loadAZero(loadAZero), .loadBad(loadBad), .status(status),
    .strobe(strobe), .modCtrl(modCtrl), .termPulse(termPulse),
    .cfgError(cfgError)
  );

endmodule

// File: rtl/pswallow_checker.sv
module pswallow_checker #(
  parameter int M_W   = 10,
  parameter int A_W   = 7,
  parameter int DEF_M = 8,
  parameter int DEF_A = 0
) (
  input logic           clk,
  input logic           rstN,
  input logic           loadEn,
  input logic [M_W-1:0] mValue,
  input logic [A_W-1:0] aValue,
  input logic           modCtrl,
  input logic           termPulse,
  input logic           cfgError
);

  localparam int CW = ((M_W > A_W) ? M_W : A_W) + 1;

  // Independent position tracker, derived only from the ports.
  logic [M_W-1:0] gapCnt;
  logic [M_W-1:0] mSeen;
  logic [A_W-1:0] aSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
      mSeen  <= M_W'(DEF_M);
      aSeen  <= A_W'(DEF_A);
    end else if (loadEn) begin
      gapCnt <= '0;
      mSeen  <= mValue;
      aSeen  <= aValue;
    end else if (termPulse) begin
      gapCnt <= '0;
    end else begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  logic [CW-1:0] gapX, mX, aX;
  logic          badNow;
  always_comb begin
    gapX   = CW'(gapCnt);
    mX     = CW'(mSeen);
    aX     = CW'(aSeen);
    badNow = (CW'(mValue) <= CW'(aValue));
  end

  p_mc_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    !modCtrl |-> (gapX < aX));

  p_mc_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    modCtrl |-> (gapX >= aX));

  p_term_at_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    termPulse |-> (gapX + CW'(1) == mX));

  p_end_has_term_r3: assert property (@(posedge clk) disable iff (!rstN)
    (gapX + CW'(1) == mX) |-> termPulse);

  p_load_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> !termPulse);

  p_err_on_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (cfgError == $past(badNow)));

  p_err_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> $stable(cfgError));

endmodule

bind pswallow_counter pswallow_checker #(
  .M_W(M_W), .A_W(A_W), .DEF_M(DEF_M), .DEF_A(DEF_A)
) i_checker (.*);

// File: tb/test_pswallow_counter.sv
module test_pswallow_counter;

  localparam int CLK_PERIOD = 10;
  localparam int M_W = 10;
  localparam int A_W = 7;
  localparam int NVEC = 9;

  // {expected cfgError, M, A}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 10'd8,    7'd0},
    {1'b0, 10'd8,    7'd3},
    {1'b0, 10'd20,   7'd7},
    {1'b0, 10'd100,  7'd99},
    {1'b0, 10'd1023, 7'd127},
    {1'b1, 10'd10,   7'd10},
    {1'b1, 10'd9,    7'd20},
    {1'b0, 10'd300,  7'd1},
    {1'b0, 10'd12,   7'd11}
  };

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           loadEn = 1'b0;
  logic [M_W-1:0] mValue = '0;
  logic [A_W-1:0] aValue = '0;
  logic           modCtrl, termPulse, cfgError;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pswallow_counter i_pswallow_counter (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .mValue(mValue),
    .aValue(aValue), .modCtrl(modCtrl), .termPulse(termPulse),
    .cfgError(cfgError)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge; loads, then follows the given number of full cycles.
  task automatic loadAndWatch(input int m, input int a, input int expErr, input int cycles);
    loadEn = 1'b1;
    mValue = M_W'(m);
    aValue = A_W'(a);
    @(negedge clk);
    loadEn = 1'b0;
    check("R6 error flag after load", int'(cfgError), expErr);
    for (int i = 0; i < cycles * m; i++) begin
      int k = i % m;
      if (a == 0)     check("R4 modCtrl with A=0", int'(modCtrl), 1);
      else if (k < a) check("R1 modCtrl low phase", int'(modCtrl), 0);
      else            check("R2 modCtrl high phase", int'(modCtrl), 1);
      check("R3 terminal pulse position", int'(termPulse), (k == m - 1) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8: reset state is period 0 of M=8, A=0
    check("R8 reset modCtrl", int'(modCtrl), 1);
    check("R8 reset termPulse", int'(termPulse), 0);
    check("R8 reset cfgError", int'(cfgError), 0);
    for (int k = 1; k < 16; k++) begin
      @(negedge clk);
      check("R8 default cycle pulse", int'(termPulse), ((k % 8) == 7) ? 1 : 0);
      check("R8 default modCtrl", int'(modCtrl), 1);
    end
    @(negedge clk);

    // Vector table; entry 4 covers R7 (M=1023, A=127), entries 5 and 6 cover R6.
    for (int v = 0; v < NVEC; v++) begin
      loadAndWatch(int'(VEC[v][16:7]), int'(VEC[v][6:0]), int'(VEC[v][17]), 2);
    end

    // R5: reload in the middle of a cycle
    loadAndWatch(50, 5, 0, 0);
    repeat (16) @(negedge clk);
    loadEn = 1'b1;
    mValue = 10'd12;
    aValue = 7'd4;
    @(negedge clk);
    loadEn = 1'b0;
    check("R5 restart modCtrl low", int'(modCtrl), 0);
    check("R5 restart no pulse", int'(termPulse), 0);
    begin
      int firstPulse = -1;
      for (int k = 1; k < 12; k++) begin
        @(negedge clk);
        if (k == 4) check("R5 modCtrl rises at new A", int'(modCtrl), 1);
        if (termPulse && firstPulse < 0) firstPulse = k;
      end
      check("R5 first pulse after reload", firstPulse, 11);
    end

    // R6: a good load clears the flag, a bad one sets it, and the flag holds
    @(negedge clk);
    loadAndWatch(15, 15, 1, 1);
    repeat (5) @(negedge clk);
    check("R6 flag holds without load", int'(cfgError), 1);
    loadAndWatch(15, 14, 0, 1);

    finishRun();
  end

endmodule